// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

The block gathers eight single-cycle event pulses into one 8-bit pending register and reports them to a host through a small register bus. The host reads a status register whose content is cleared by the read, and writes a mask register that suppresses chosen sources. One active-high interrupt line tells the host that an unmasked event is waiting.

Three sources are conditioned before they are latched. A framing-change event is derived from any edge of a synchronisation-state level. An input-mismatch event is one-shot: after it fires it is disarmed until the host strobes a separate detail-read line. A transfer-window event is accepted only while at least one of two channel enables is high. Masked events are kept internally and become visible as soon as their mask bit is cleared. The frame-sync source is the exception: it is always visible in the status register, but it raises the interrupt only when its mask bit is clear. Every mask write forces the interrupt low for two cycles before it is evaluated again.

Top module: `intStatusCtl`

## Requirements
- R1: After reset the mask is 0x00, no event is pending, `irqOut` is 0 and `busRdata` is 0x00.
- R2: Status bit map, bit 7 down to bit 0: timer, frame-sync, command-done, monitor-active, framing-change, input-mismatch, window-open, window-overflow. An unmasked event sets its bit and raises `irqOut` in the cycle after the pulse.
- R3: A read at address 0 returns the visible pending bits in `busRdata` one cycle later and clears exactly those bits. The mask at address 1 is write-only, and a read there returns 0x00.
- R4: An event that arrives in the same cycle as a status read is not cleared by that read. It is returned by the next read.
- R5: A mask bit of 1 hides its pending event from the status and from `irqOut`. The event is kept, and it is returned by the first read after the mask bit is cleared.
- R6: A pending frame-sync event (bit 6) is returned by a status read even while it is masked. While masked, it does not raise `irqOut`.
- R7: After any mask write, `irqOut` is 0 for exactly 2 cycles. It then follows the pending and mask state again.
- R8: An input-mismatch pulse sets bit 2 only while the source is armed. Firing disarms the source. A pulse on `mismatchDetailRd` re-arms it from the next cycle.
- R9: Each change of `syncState`, rising or falling, sets bit 3. Its level after reset is taken as 0.
- R10: A window-open pulse sets bit 1 only while `chanEnA` or `chanEnB` is 1.
- R11: A status read leaves masked pending bits other than bit 6 in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register address (0 status, 1 mask) |
| busRd | input | 1 | Read strobe, one cycle |
| busWr | input | 1 | Write strobe, one cycle |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| irqOut | output | 1 | Active-high interrupt to host |
| timerEvt | input | 1 | Timer event pulse (bit 7) |
| frameSyncEvt | input | 1 | Frame-sync event pulse (bit 6) |
| cmdDoneEvt | input | 1 | Command-done event pulse (bit 5) |
| monActEvt | input | 1 | Monitor-active event pulse (bit 4) |
| syncState | input | 1 | Synchronisation-state level; edges make bit 3 |
| mismatchEvt | input | 1 | Input-mismatch pulse (bit 2) |
| mismatchDetailRd | input | 1 | Detail-register read strobe that re-arms bit 2 |
| winOpenEvt | input | 1 | Transfer window open pulse (bit 1) |
| winOvfEvt | input | 1 | Transfer window overflow pulse (bit 0) |
| chanEnA | input | 1 | Synchronous channel A enable |
| chanEnB | input | 1 | Synchronous channel B enable |

## Verification
A pending bit that is wrongly lost or wrongly kept shows in the next status read, one cycle after the read strobe. It also shows on `irqOut` one cycle after the event, provided no mask-write hold is running. A wrong mismatch arm state shows as a missing or extra bit 2 on the read that follows the second pulse. A hold counter that is off by one changes `irqOut` in the first, second or third cycle after a mask write, so the bench samples each of those cycles. Masked sources and bit 6 are checked twice, once before and once after unmasking, so that hidden state becomes visible at the ports.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned BIT_TIMER = 7;
  localparam int unsigned BIT_FSYNC = 6;
  localparam int unsigned BIT_CMD   = 5;
  localparam int unsigned BIT_MON   = 4;
  localparam int unsigned BIT_FRAME = 3;
  localparam int unsigned BIT_MISM  = 2;
  localparam int unsigned BIT_WOPEN = 1;
  localparam int unsigned BIT_WOVF  = 0;
  localparam logic [STAT_W-1:0] ALWAYS_VIS = STAT_W'(1) << BIT_FSYNC;

  typedef struct packed {
    logic statRd;
    logic otherRd;
    logic maskWr;
  } iscStrobe_t;
endpackage

// File: rtl/iscEvtCond.sv
module iscEvtCond
  import isc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              timerEvt,
  input  logic              frameSyncEvt,
  input  logic              cmdDoneEvt,
  input  logic              monActEvt,
  input  logic              syncState,
  input  logic              mismatchEvt,
  input  logic              mismatchDetailRd,
  input  logic              winOpenEvt,
  input  logic              winOvfEvt,
  input  logic              chanEnA,
  input  logic              chanEnB,
  output logic [STAT_W-1:0] evtVec
);
  logic syncPrev;
  logic mmArmed;
  logic mmAccept;

  assign mmAccept = mismatchEvt && mmArmed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      mmArmed  <= 1'b1;
    end else begin
      syncPrev <= syncState;
      if (mismatchDetailRd) mmArmed <= 1'b1;
      else if (mmAccept)    mmArmed <= 1'b0;
    end
  end

  always_comb begin
    evtVec            = '0;
    evtVec[BIT_TIMER] = timerEvt;
    evtVec[BIT_FSYNC] = frameSyncEvt;
    evtVec[BIT_CMD]   = cmdDoneEvt;
    evtVec[BIT_MON]   = monActEvt;
    evtVec[BIT_FRAME] = syncState ^ syncPrev;
    evtVec[BIT_MISM]  = mmAccept;
    evtVec[BIT_WOPEN] = winOpenEvt && (chanEnA || chanEnB);
    evtVec[BIT_WOVF]  = winOvfEvt;
  end

  // a disarmed mismatch source cannot produce an event in the same cycle
  AST_MISM_ONESHOT: assert property (@(posedge clk) disable iff (!rstN)
    (!mmArmed && mismatchEvt) |-> !evtVec[BIT_MISM]); // R8
endmodule

// File: rtl/iscDatapath.sv
module iscDatapath
  import isc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  iscStrobe_t        strb,
  input  logic [STAT_W-1:0] wdata,
  input  logic [STAT_W-1:0] evtVec,
  output logic [STAT_W-1:0] rdata,
  output logic              irqCond
);
  logic [STAT_W-1:0] pendReg;
  logic [STAT_W-1:0] maskReg;
  logic [STAT_W-1:0] visMask;
  logic [STAT_W-1:0] readVal;
  logic [STAT_W-1:0] clrVec;

  assign visMask = ~maskReg | ALWAYS_VIS;
  assign readVal = pendReg & visMask;
  assign clrVec  = strb.statRd ? readVal : '0;
  assign irqCond = |(pendReg & ~maskReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendReg <= '0;
      maskReg <= '0;
      rdata   <= '0;
    end else begin
      pendReg <= (pendReg & ~clrVec) | evtVec;
      if (strb.maskWr) maskReg <= wdata;
      if (strb.statRd)       rdata <= readVal;
      else if (strb.otherRd) rdata <= '0;
    end
  end

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statRd && evtVec == '0) |=> ((pendReg & $past(visMask)) == '0)); // R3

  AST_MASKED_HIDDEN: assert property (@(posedge clk) disable iff (!rstN)
    strb.statRd |=> ((rdata & $past(maskReg) & ~ALWAYS_VIS) == '0)); // R5

  AST_FSYNC_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statRd && pendReg[BIT_FSYNC]) |=> rdata[BIT_FSYNC]); // R6
endmodule

// File: rtl/iscControl.sv
module iscControl
  import isc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned STAT_ADDR = 0,
  parameter int unsigned MASK_ADDR = 1,
  parameter int unsigned HOLD_CYC  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              irqCond,
  output iscStrobe_t        strb,
  output logic              irqOut
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);
  localparam logic [CNT_W-1:0]  HOLD_LOAD = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] holdCnt;

  assign strb.statRd  = busRd && (busAddr == A_STAT);
  assign strb.otherRd = busRd && (busAddr != A_STAT);
  assign strb.maskWr  = busWr && (busAddr == A_MASK);

  always_ff @(posedge clk) begin
    if (!rstN) holdCnt <= '0;
    else if (strb.maskWr) holdCnt <= HOLD_LOAD;
    else if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
  end

  assign irqOut = irqCond && (holdCnt == '0);

  AST_MASK_WR_DROP: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskWr |=> !irqOut); // R7
endmodule

// File: rtl/intStatusCtl.sv
module intStatusCtl
  import isc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned STAT_ADDR = 0,
  parameter int unsigned MASK_ADDR = 1,
  parameter int unsigned HOLD_CYC  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [STAT_W-1:0] busWdata,
  output logic [STAT_W-1:0] busRdata,
  output logic              irqOut,
  input  logic              timerEvt,
  input  logic              frameSyncEvt,
  input  logic              cmdDoneEvt,
  input  logic              monActEvt,
  input  logic              syncState,
  input  logic              mismatchEvt,
  input  logic              mismatchDetailRd,
  input  logic              winOpenEvt,
  input  logic              winOvfEvt,
  input  logic              chanEnA,
  input  logic              chanEnB
);
  iscStrobe_t        strb;
  logic [STAT_W-1:0] evtVec;
  logic              irqCond;

  iscEvtCond u_evt (
    .clk(clk), .rstN(rstN),
    .timerEvt(timerEvt), .frameSyncEvt(frameSyncEvt),
    .cmdDoneEvt(cmdDoneEvt), .monActEvt(monActEvt),
    .syncState(syncState), .mismatchEvt(mismatchEvt),
    .mismatchDetailRd(mismatchDetailRd),
    .winOpenEvt(winOpenEvt), .winOvfEvt(winOvfEvt),
    .chanEnA(chanEnA), .chanEnB(chanEnB),
    .evtVec(evtVec)
  );

  iscDatapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata),
    .evtVec(evtVec), .rdata(busRdata), .irqCond(irqCond)
  );

  iscControl #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
    .MASK_ADDR(MASK_ADDR), .HOLD_CYC(HOLD_CYC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .irqCond(irqCond), .strb(strb), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_intStatusCtl.sv
module sim_intStatusCtl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic busRd = 1'b0, busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic irqOut;
  logic timerEvt = 0, frameSyncEvt = 0, cmdDoneEvt = 0, monActEvt = 0;
  logic syncState = 0, mismatchEvt = 0, mismatchDetailRd = 0;
  logic winOpenEvt = 0, winOvfEvt = 0, chanEnA = 0, chanEnB = 0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  intStatusCtl u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .timerEvt(timerEvt), .frameSyncEvt(frameSyncEvt), .cmdDoneEvt(cmdDoneEvt),
    .monActEvt(monActEvt), .syncState(syncState), .mismatchEvt(mismatchEvt),
    .mismatchDetailRd(mismatchDetailRd), .winOpenEvt(winOpenEvt),
    .winOvfEvt(winOvfEvt), .chanEnA(chanEnA), .chanEnB(chanEnB)
  );

  // {mask, events (bit3 = toggle syncState), expected read, expected irq}
  localparam logic [31:0] VEC_TAB [0:7] = '{
    32'h00_80_80_01, 32'h00_21_21_01, 32'hFF_40_40_00, 32'h40_48_48_01,
    32'h0F_0C_00_00, 32'h00_04_04_01, 32'hF0_12_02_01, 32'hBF_40_40_01
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wrMask(input logic [7:0] v);
    @(negedge clk); busAddr = 2'd1; busWr = 1'b1; busWdata = v;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic pulseEvt(input logic [7:0] e);
    @(negedge clk);
    timerEvt = e[7]; frameSyncEvt = e[6]; cmdDoneEvt = e[5]; monActEvt = e[4];
    if (e[3]) syncState = ~syncState;
    mismatchEvt = e[2]; winOpenEvt = e[1]; winOvfEvt = e[0];
    @(negedge clk);
    {timerEvt, frameSyncEvt, cmdDoneEvt, monActEvt} = '0;
    {mismatchEvt, winOpenEvt, winOvfEvt} = '0;
  endtask

  task automatic detailRd();
    @(negedge clk); mismatchDetailRd = 1'b1;
    @(negedge clk); mismatchDetailRd = 1'b0;
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {7'b0, irqOut}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", busRdata, 8'h00);
    check("R1 irq after reset", {7'b0, irqOut}, 8'h00);
    rdReg(2'd0);
    check("R1 empty status", busRdata, 8'h00);

    chanEnA = 1'b1;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] m, e, x, q;
      {m, e, x, q} = VEC_TAB[i];
      wrMask(m);
      repeat (3) @(negedge clk);
      pulseEvt(e);
      check("R2/R5/R6 irq", {7'b0, irqOut}, q);
      rdReg(2'd0);
      check("R2/R3/R6/R9 status", busRdata, x);
      wrMask(8'h00);
      repeat (3) @(negedge clk);
      rdReg(2'd0);
      check("R5/R11 held after unmask", busRdata, e & m & 8'hBF);
      detailRd();
    end

    // R4: event coincident with read survives
    @(negedge clk); busAddr = 2'd0; busRd = 1'b1; timerEvt = 1'b1;
    @(negedge clk); busRd = 1'b0; timerEvt = 1'b0;
    check("R4 coincident read", busRdata, 8'h00);
    rdReg(2'd0);
    check("R4 event kept", busRdata, 8'h80);

    // R7: 2-cycle drop on mask write
    pulseEvt(8'h20);
    check("R7 irq before write", {7'b0, irqOut}, 8'h01);
    @(negedge clk); busAddr = 2'd1; busWr = 1'b1; busWdata = 8'h00;
    @(negedge clk); busWr = 1'b0;
    check("R7 drop cycle 1", {7'b0, irqOut}, 8'h00);
    @(negedge clk);
    check("R7 drop cycle 2", {7'b0, irqOut}, 8'h00);
    @(negedge clk);
    check("R7 reasserted", {7'b0, irqOut}, 8'h01);
    rdReg(2'd0);
    check("R7 status", busRdata, 8'h20);

    // R3: mask is write-only
    wrMask(8'hFF);
    rdReg(2'd1);
    check("R3 mask addr reads zero", busRdata, 8'h00);
    wrMask(8'h00);
    repeat (3) @(negedge clk);

    // R8: mismatch one-shot
    pulseEvt(8'h04);
    rdReg(2'd0);
    check("R8 first mismatch", busRdata, 8'h04);
    pulseEvt(8'h04);
    check("R8 ignored irq", {7'b0, irqOut}, 8'h00);
    rdReg(2'd0);
    check("R8 ignored status", busRdata, 8'h00);
    detailRd();
    pulseEvt(8'h04);
    rdReg(2'd0);
    check("R8 rearmed", busRdata, 8'h04);

    // R10: window-open gated by channel enables
    chanEnA = 1'b0; chanEnB = 1'b0;
    pulseEvt(8'h02);
    rdReg(2'd0);
    check("R10 gated off", busRdata, 8'h00);
    chanEnB = 1'b1;
    pulseEvt(8'h02);
    rdReg(2'd0);
    check("R10 enabled by B", busRdata, 8'h02);

    // R11: read keeps masked bits
    wrMask(8'h01);
    repeat (3) @(negedge clk);
    pulseEvt(8'h81);
    rdReg(2'd0);
    check("R11 visible only", busRdata, 8'h80);
    wrMask(8'h00);
    rdReg(2'd0);
    check("R11 masked kept", busRdata, 8'h01);

    finishRun();
  end
endmodule